// File: doc/BRIEF.md
# Local Master Request Sequencer

This block sits between user logic and the local-master side of a bus-interface core. User logic describes one transfer: a start address, a 4-bit bus command, a burst length in data beats, a 32- or 64-bit width, a direction and an optional request hold for fast back-to-back use. The block then raises the matching active-low request line with the address, command and length, and waits for the core's grant. From then on it follows the 2-bit phase status that the core reports.

During the data phase the block moves one beat per qualified lower-lane strobe. Write beats are taken from a small local buffer, and read beats are captured into that same buffer. In 64-bit mode an upper-lane strobe qualifies the upper half of each beat. When the status falls back to the idle phase, the block ends the job. It raises a one-cycle completion pulse, reports how many beats moved, and flags a transfer that stopped short of its burst length.

User logic fills the buffer before a write and reads it back after a read through a simple indexed port.

Top module: `lm_req_seq`

## Requirements
- R1: A start request is accepted only while `lm_stat` is 2'b00 (idle/termination phase). A start seen under any other status is dropped: both request lines stay high and `usr_busy` stays low.
- R2: A 32-bit job drives `req32_n` low and keeps `req64_n` high. A 64-bit job drives `req64_n` low and keeps `req32_n` high. The two lines are never low together, and both are high after reset.
- R3: In every cycle a request line is low, `ad_out`, `cben_out` and `blen_out` carry the job's address, command and length, from the first such cycle onward. In all other cycles they are zero.
- R4: The sequencer leaves the request phase only in a cycle where `gnt_n` is low and `lm_stat` is 2'b01 (address phase). While `gnt_n` stays high, the request stays asserted whatever the status is.
- R5: Without the hold option, the request line goes high in the cycle after the granted address phase is seen. With the hold option, it stays low until the completion cycle.
- R6: A beat is accepted only in a cycle where the sequencer is in its data phase, `lm_stat` is 2'b10 (transfer phase) and `xfer_lo_n` is low. Cycles without the strobe move no data.
- R7: `usr_done` is high for exactly one cycle: the cycle after the status returns to 2'b00 during the data phase. `usr_busy` is low in that cycle.
- R8: `usr_count` is cleared when a job is accepted and counts accepted beats. It never exceeds the burst length, and strobes beyond the length are ignored. `usr_early` is high together with `usr_done` when fewer beats than the length were accepted.
- R9: For a write job, `wdata_out` presents buffer entry k during beat k. The entry index starts at 0 and advances by one per accepted beat.
- R10: For a read job, an accepted beat k stores `rdata_in[31:0]` into the lower half of entry k. The upper half takes `rdata_in[63:32]` only in 64-bit mode and only when `xfer_hi_n` is low in the same cycle; otherwise it keeps its old value. A write job never changes the buffer.
- R11: With `buf_we` high, the user port writes `buf_wdata` to entry `buf_idx` at the clock edge. `buf_rdata` shows entry `buf_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_start | input | 1 | Request to begin a job |
| usr_addr | input | ADDR_W | Job start address |
| usr_cmd | input | 4 | Job bus command |
| usr_len | input | LEN_W | Burst length in beats |
| usr_wide | input | 1 | 1 selects 64-bit job |
| usr_write | input | 1 | 1 selects write job, 0 read |
| usr_hold | input | 1 | Hold request through the job (fast back-to-back) |
| usr_busy | output | 1 | Job in progress |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_early | output | 1 | Completed short of burst length |
| usr_count | output | LEN_W | Beats accepted in the current or last job |
| buf_we | input | 1 | User buffer write enable |
| buf_idx | input | IDX_W | User buffer entry index |
| buf_wdata | input | 64 | User buffer write data |
| buf_rdata | output | 64 | User buffer read data |
| req32_n | output | 1 | Active-low 32-bit request |
| req64_n | output | 1 | Active-low 64-bit request |
| ad_out | output | ADDR_W | Request address |
| cben_out | output | 4 | Request command |
| blen_out | output | LEN_W | Request burst length |
| gnt_n | input | 1 | Active-low grant from core |
| lm_stat | input | 2 | Core phase status |
| xfer_lo_n | input | 1 | Active-low lower-lane beat strobe |
| xfer_hi_n | input | 1 | Active-low upper-lane strobe |
| rdata_in | input | 64 | Read data from core |
| wdata_out | output | 64 | Write data to core |

## Verification
The main path is exercised with three jobs. The first is a 32-bit write with a wait cycle and surplus strobes, which shows whether beats follow the strobe and whether the length cap holds. The second is a 64-bit read with the hold option that mixes upper-lane strobes on and off, which separates lane qualification and the request-drop timing. The third is a 32-bit read ended early with the upper strobe asserted, which shows the upper half being ignored in narrow mode and the short-transfer flag. A start under the wrong status and an address phase shown before the grant show whether the sequencer waits correctly.

// File: rtl/lmseq_pkg.sv
package lmseq_pkg;
  localparam int LANE_W = 32;
  localparam int DATA_W = 2 * LANE_W;

  typedef enum logic [1:0] {
    ST_TERM = 2'b00,
    ST_ADDR = 2'b01,
    ST_XFER = 2'b10,
    ST_RSVD = 2'b11
  } bus_stat_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_REQ  = 2'b01,
    SQ_DATA = 2'b10
  } seq_state_e;

  typedef struct packed {
    logic wide;
    logic write;
    logic hold;
  } job_mode_t;
endpackage

// File: rtl/lmseq_ctrl.sv
module lmseq_ctrl
  import lmseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  input  logic [LEN_W-1:0]  len,
  input  job_mode_t         mode,
  input  logic              gnt_n,
  input  logic [1:0]        stat,
  input  logic              short_xfer,
  output logic              load,
  output logic              in_xfer,
  output logic              busy,
  output job_mode_t         mode_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              req32_n,
  output logic              req64_n,
  output logic [ADDR_W-1:0] ad_out,
  output logic [3:0]        cben_out,
  output logic [LEN_W-1:0]  blen_out,
  output logic              done,
  output logic              early
);
  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;
  logic              done_d, early_d, done_q, early_q;
  logic              req_on;

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    done_d  = 1'b0;
    early_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start && stat == ST_TERM) begin
        st_d = SQ_REQ;
        load = 1'b1;
      end
      SQ_REQ: if (!gnt_n && stat == ST_ADDR) st_d = SQ_DATA;
      SQ_DATA: if (stat == ST_TERM) begin
        st_d    = SQ_IDLE;
        done_d  = 1'b1;
        early_d = short_xfer;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      done_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      early_q <= early_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      len_q  <= '0;
      mode_q <= '0;
    end else if (load) begin
      addr_q <= addr;
      cmd_q  <= cmd;
      len_q  <= len;
      mode_q <= mode;
    end
  end

  assign req_on   = (st_q == SQ_REQ) || (st_q == SQ_DATA && mode_q.hold);
  assign req32_n  = !(req_on && !mode_q.wide);
  assign req64_n  = !(req_on && mode_q.wide);
  assign ad_out   = req_on ? addr_q : '0;
  assign cben_out = req_on ? cmd_q  : '0;
  assign blen_out = req_on ? len_q  : '0;
  assign in_xfer  = (st_q == SQ_DATA) && (stat == ST_XFER);
  assign busy     = (st_q != SQ_IDLE);
  assign done     = done_q;
  assign early    = early_q;
endmodule

// File: rtl/lmseq_wcnt.sv
module lmseq_wcnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             live,
  input  logic             lo_n,
  input  logic [LEN_W-1:0] len,
  output logic             accept,
  output logic             short_xfer,
  output logic [LEN_W-1:0] cnt
);
  logic [LEN_W-1:0] cnt_q, cnt_d;

  assign short_xfer = (cnt_q < len);
  assign accept     = live && !lo_n && short_xfer;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (accept) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lmseq_buf.sv
module lmseq_buf
  import lmseq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic              bus_we_lo,
  input  logic              bus_we_hi,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              usr_we,
  input  logic [IDX_W-1:0]  usr_idx,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic [DATA_W-1:0] usr_rdata
);
  logic [DATA_W-1:0] ent_all [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic              bus_sel, usr_sel;
    assign bus_sel = (bus_idx == IDX_W'(i));
    assign usr_sel = usr_we && (usr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (bus_we_lo && bus_sel)  ent_q[LANE_W-1:0] <= bus_wdata[LANE_W-1:0];
      else if (usr_sel)          ent_q[LANE_W-1:0] <= usr_wdata[LANE_W-1:0];
      if (bus_we_hi && bus_sel)  ent_q[DATA_W-1:LANE_W] <= bus_wdata[DATA_W-1:LANE_W];
      else if (usr_sel)          ent_q[DATA_W-1:LANE_W] <= usr_wdata[DATA_W-1:LANE_W];
    end
    assign ent_all[i] = ent_q;
  end

  assign bus_rdata = ent_all[bus_idx];
  assign usr_rdata = ent_all[usr_idx];
endmodule

// File: rtl/lm_req_seq.sv
module lm_req_seq
  import lmseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int BUF_DEPTH = 16,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_start,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [3:0]        usr_cmd,
  input  logic [LEN_W-1:0]  usr_len,
  input  logic              usr_wide,
  input  logic              usr_write,
  input  logic              usr_hold,
  output logic              usr_busy,
  output logic              usr_done,
  output logic              usr_early,
  output logic [LEN_W-1:0]  usr_count,
  input  logic              buf_we,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [63:0]       buf_wdata,
  output logic [63:0]       buf_rdata,
  output logic              req32_n,
  output logic              req64_n,
  output logic [ADDR_W-1:0] ad_out,
  output logic [3:0]        cben_out,
  output logic [LEN_W-1:0]  blen_out,
  input  logic              gnt_n,
  input  logic [1:0]        lm_stat,
  input  logic              xfer_lo_n,
  input  logic              xfer_hi_n,
  input  logic [63:0]       rdata_in,
  output logic [63:0]       wdata_out
);
  job_mode_t        mode_in, mode_q;
  logic [LEN_W-1:0] len_q;
  logic             load, in_xfer, short_xfer, accept;
  logic             bus_we_lo, bus_we_hi;
  logic [IDX_W-1:0] beat_idx;

  assign mode_in = '{wide: usr_wide, write: usr_write, hold: usr_hold};

  lmseq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(usr_start), .addr(usr_addr),
    .cmd(usr_cmd), .len(usr_len), .mode(mode_in), .gnt_n(gnt_n),
    .stat(lm_stat), .short_xfer(short_xfer), .load(load),
    .in_xfer(in_xfer), .busy(usr_busy), .mode_q(mode_q), .len_q(len_q),
    .req32_n(req32_n), .req64_n(req64_n), .ad_out(ad_out),
    .cben_out(cben_out), .blen_out(blen_out), .done(usr_done),
    .early(usr_early)
  );

  lmseq_wcnt #(.LEN_W(LEN_W)) u_wcnt (
    .clk(clk), .rst_n(rst_n), .clr(load), .live(in_xfer),
    .lo_n(xfer_lo_n), .len(len_q), .accept(accept),
    .short_xfer(short_xfer), .cnt(usr_count)
  );

  assign beat_idx  = IDX_W'(usr_count);
  assign bus_we_lo = accept && !mode_q.write;
  assign bus_we_hi = bus_we_lo && mode_q.wide && !xfer_hi_n;

  lmseq_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .bus_idx(beat_idx), .bus_we_lo(bus_we_lo),
    .bus_we_hi(bus_we_hi), .bus_wdata(rdata_in), .bus_rdata(wdata_out),
    .usr_we(buf_we), .usr_idx(buf_idx), .usr_wdata(buf_wdata),
    .usr_rdata(buf_rdata)
  );
endmodule

// File: rtl/lmseq_chk.sv
module lmseq_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req32_n,
  input logic              req64_n,
  input logic [ADDR_W-1:0] ad_out,
  input logic [3:0]        cben_out,
  input logic [LEN_W-1:0]  blen_out,
  input logic [1:0]        lm_stat,
  input logic              usr_done,
  input logic [LEN_W-1:0]  usr_count,
  input logic [LEN_W-1:0]  len_q
);
  logic req_any;
  assign req_any = !req32_n || !req64_n;

  assert_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!req32_n && !req64_n));

  assert_start_in_term_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_any) |-> $past(lm_stat) == 2'b00);

  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_any && $past(req_any)) |->
      ($stable(ad_out) && $stable(cben_out) && $stable(blen_out)));

  assert_fields_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |-> (ad_out == '0 && cben_out == '0 && blen_out == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |=> !usr_done);

  assert_done_after_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |-> $past(lm_stat) == 2'b00);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    usr_count <= len_q);
endmodule

bind lm_req_seq lmseq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req32_n(req32_n), .req64_n(req64_n),
  .ad_out(ad_out), .cben_out(cben_out), .blen_out(blen_out),
  .lm_stat(lm_stat), .usr_done(usr_done), .usr_count(usr_count),
  .len_q(len_q)
);

// File: tb/sim_lm_req_seq.sv
module sim_lm_req_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic usr_start, usr_wide, usr_write, usr_hold;
  logic [ADDR_W-1:0] usr_addr;
  logic [3:0] usr_cmd;
  logic [LEN_W-1:0] usr_len;
  logic usr_busy, usr_done, usr_early;
  logic [LEN_W-1:0] usr_count;
  logic buf_we;
  logic [IDX_W-1:0] buf_idx;
  logic [63:0] buf_wdata, buf_rdata;
  logic req32_n, req64_n;
  logic [ADDR_W-1:0] ad_out;
  logic [3:0] cben_out;
  logic [LEN_W-1:0] blen_out;
  logic gnt_n, xfer_lo_n, xfer_hi_n;
  logic [1:0] lm_stat;
  logic [63:0] rdata_in, wdata_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] exp_mem [DEPTH];
  logic [63:0] exp_q [$];
  logic beat_live = 1'b0;
  logic cur_wide, cur_write;
  int bptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lm_req_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .usr_start(usr_start), .usr_addr(usr_addr),
    .usr_cmd(usr_cmd), .usr_len(usr_len), .usr_wide(usr_wide),
    .usr_write(usr_write), .usr_hold(usr_hold), .usr_busy(usr_busy),
    .usr_done(usr_done), .usr_early(usr_early), .usr_count(usr_count),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .req32_n(req32_n), .req64_n(req64_n),
    .ad_out(ad_out), .cben_out(cben_out), .blen_out(blen_out),
    .gnt_n(gnt_n), .lm_stat(lm_stat), .xfer_lo_n(xfer_lo_n),
    .xfer_hi_n(xfer_hi_n), .rdata_in(rdata_in), .wdata_out(wdata_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Monitor: pops expected write words and compares at the strobed beat (R9)
  always @(negedge clk) begin
    if (rst_n && beat_live) begin
      if (exp_q.size() == 0) chk("R9 empty queue", wdata_out, 64'hx);
      else chk("R9 write data", wdata_out, exp_q.pop_front());
    end
  end

  task automatic begin_job(input logic [ADDR_W-1:0] a, input logic [3:0] c,
                           input logic [LEN_W-1:0] l, input logic w64,
                           input logic wr, input logic hold);
    tick();
    usr_addr = a; usr_cmd = c; usr_len = l;
    usr_wide = w64; usr_write = wr; usr_hold = hold;
    usr_start = 1'b1; lm_stat = 2'b00; gnt_n = 1'b1;
    cur_wide = w64; cur_write = wr; bptr = 0;
    tick();
    usr_start = 1'b0;
    @(negedge clk);
    chk("R2 req32_n", {63'd0, req32_n}, {63'd0, w64});
    chk("R2 req64_n", {63'd0, req64_n}, {63'd0, !w64});
    chk("R3 ad_out", {32'd0, ad_out}, {32'd0, a});
    chk("R3 cben_out", {60'd0, cben_out}, {60'd0, c});
    chk("R3 blen_out", {56'd0, blen_out}, {56'd0, l});
    chk("R8 count cleared", {56'd0, usr_count}, 64'd0);
    // R4: address phase shown before grant must not advance
    tick();
    lm_stat = 2'b01;
    @(negedge clk);
    chk("R4 req held no grant", {63'd0, req32_n & req64_n}, 64'd0);
    tick();
    @(negedge clk);
    chk("R4 req held no grant 2", {63'd0, req32_n & req64_n}, 64'd0);
    tick();
    gnt_n = 1'b0;
    @(negedge clk);
    chk("R4 req held at grant", {63'd0, req32_n & req64_n}, 64'd0);
    tick();
    lm_stat = 2'b10; xfer_lo_n = 1'b1; xfer_hi_n = 1'b1;
    @(negedge clk);
    chk("R5 request after address phase", {63'd0, req32_n & req64_n}, {63'd0, !hold});
    if (!hold) chk("R3 ad_out zero after drop", {32'd0, ad_out}, 64'd0);
  endtask

  task automatic do_beat(input logic hi_on, input logic counted, input logic [63:0] rd);
    tick();
    xfer_lo_n = 1'b0; xfer_hi_n = !hi_on; rdata_in = rd;
    beat_live = counted && cur_write;
    if (counted) begin
      if (cur_write) exp_q.push_back(exp_mem[bptr]);
      else begin
        exp_mem[bptr][31:0] = rd[31:0];
        if (cur_wide && hi_on) exp_mem[bptr][63:32] = rd[63:32];
      end
      bptr++;
    end
  endtask

  task automatic wait_beat();
    tick();
    xfer_lo_n = 1'b1; xfer_hi_n = 1'b1; beat_live = 1'b0;
    rdata_in = 64'hDEAD_BEEF_DEAD_BEEF;
  endtask

  task automatic end_job(input int cnt, input logic early);
    tick();
    lm_stat = 2'b00; xfer_lo_n = 1'b1; xfer_hi_n = 1'b1; beat_live = 1'b0;
    @(negedge clk);
    chk("R7 done not yet", {63'd0, usr_done}, 64'd0);
    tick();
    gnt_n = 1'b1;
    @(negedge clk);
    chk("R7 done pulse", {63'd0, usr_done}, 64'd1);
    chk("R7 busy low", {63'd0, usr_busy}, 64'd0);
    chk("R8 early flag", {63'd0, usr_early}, {63'd0, early});
    chk("R8 beat count", {56'd0, usr_count}, 64'(cnt));
    chk("R5 request released", {62'd0, req32_n, req64_n}, 64'd3);
    tick();
    @(negedge clk);
    chk("R7 done one cycle", {63'd0, usr_done}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    usr_start = 1'b0; usr_addr = '0; usr_cmd = '0; usr_len = '0;
    usr_wide = 1'b0; usr_write = 1'b0; usr_hold = 1'b0;
    buf_we = 1'b0; buf_idx = '0; buf_wdata = '0;
    gnt_n = 1'b1; lm_stat = 2'b00; xfer_lo_n = 1'b1; xfer_hi_n = 1'b1;
    rdata_in = '0; cur_wide = 1'b0; cur_write = 1'b0; bptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset request lines", {62'd0, req32_n, req64_n}, 64'd3);
    chk("R7 reset done", {63'd0, usr_done}, 64'd0);
    rst_n = 1'b1;

    // R11: preload buffer through the user port
    for (int i = 0; i < DEPTH; i++) begin
      tick();
      buf_we = 1'b1; buf_idx = IDX_W'(i);
      buf_wdata = {32'hA000_0000 + 32'(i), 32'hB000_0000 + 32'(i)};
      exp_mem[i] = buf_wdata;
    end
    tick();
    buf_we = 1'b0; buf_idx = IDX_W'(7);
    @(negedge clk);
    chk("R11 buffer readback", buf_rdata, exp_mem[7]);

    // R1: start under address-phase status is dropped
    tick();
    lm_stat = 2'b01; usr_start = 1'b1; usr_wide = 1'b0;
    tick();
    usr_start = 1'b0; lm_stat = 2'b00;
    @(negedge clk);
    chk("R1 start dropped req", {62'd0, req32_n, req64_n}, 64'd3);
    chk("R1 start dropped busy", {63'd0, usr_busy}, 64'd0);

    // Job 1: 32-bit write, length 4, one wait cycle, two surplus strobes (R6, R8, R9)
    begin_job(32'h1000_0040, 4'h7, 8'd4, 1'b0, 1'b1, 1'b0);
    do_beat(1'b0, 1'b1, '0);
    do_beat(1'b0, 1'b1, '0);
    wait_beat();
    @(negedge clk);
    chk("R6 no beat without strobe", {56'd0, usr_count}, 64'd2);
    do_beat(1'b0, 1'b1, '0);
    do_beat(1'b0, 1'b1, '0);
    do_beat(1'b0, 1'b0, '0);
    do_beat(1'b0, 1'b0, '0);
    end_job(4, 1'b0);

    // Job 2: 64-bit read with request hold, mixed upper strobes (R2, R5, R10)
    begin_job(32'h2000_0100, 4'h6, 8'd3, 1'b1, 1'b0, 1'b1);
    do_beat(1'b1, 1'b1, 64'hC0DE_0000_FACE_0000);
    do_beat(1'b0, 1'b1, 64'hC0DE_0001_FACE_0001);
    wait_beat();
    do_beat(1'b1, 1'b1, 64'hC0DE_0002_FACE_0002);
    end_job(3, 1'b0);

    // Job 3: 32-bit read, upper strobe asserted, terminated early (R8, R10)
    begin_job(32'h3000_0200, 4'h6, 8'd5, 1'b0, 1'b0, 1'b0);
    do_beat(1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0);
    do_beat(1'b1, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0);
    end_job(2, 1'b1);

    // R10: buffer contents after the reads; entry 3 untouched by the writes
    for (int i = 0; i < 5; i++) begin
      tick();
      buf_idx = IDX_W'(i);
      @(negedge clk);
      chk($sformatf("R10 entry %0d", i), buf_rdata, exp_mem[i]);
    end

    if (exp_q.size() != 0) chk("R9 leftover beats", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule